// File: doc/BRIEF.md
# Serial Control Register Port

This block is a serial slave that lets a host read and write a bank of 8-bit control registers over a four-wire synchronous serial link. The host lowers chip select and clocks in an 8-bit command. The command gives the direction, a byte count from one to four, and a start address. The data bytes follow on the same clock: either the host shifts them in, or the port shifts them out. The whole register bank is presented as a flat parallel bus to the datapath that the registers configure.

Register 0 holds the port's own framing controls. Bit 6 chooses the bit order on the wire. Bit 7 chooses whether read data leaves on the shared data pin, which is split here into an input, an output and an output enable for the pad, or on the dedicated output pin. A write to register 0 retunes the port as soon as that byte lands. Any later bytes of the same transfer already move with the new order and the new address direction. The serial inputs are oversampled by the system clock: the serial clock must stay high and low for at least four system clocks each.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset every register reads 0 (MSB first, read data on `sdo`), `sdio_oe` is 0 and `sdo` is 0.
- R2: The first byte of a transfer is the command: bit 7 = 1 for read and 0 for write, bits 6:5 = byte count minus one, bits 4:0 = start address. A read returns the register contents in the data bytes that follow.
- R3: A data byte is written into the register bank only after its eighth bit has been sampled on a rising serial-clock edge. Any other change of the bank is impossible.
- R4: Within a transfer the address steps down by one per byte in MSB-first order and up by one in LSB-first order, wrapping modulo 32.
- R5: Register 0 bit 6 = 0 shifts command and data MSB first. A value of 1 shifts both LSB first.
- R6: Register 0 bit 7 = 0 sends read bits on `sdo` with `sdio_oe` low. A value of 1 sends them on `sdio_o` with `sdio_oe` high, and `sdio_oe` is only high while chip select was active.
- R7: A write to register 0 takes effect for the bit order and address step of the remaining bytes of the same transfer.
- R8: Raising `cs_n` in mid-byte discards the partial byte. The next transfer starts again with a command byte.
- R9: Bits clocked after the last counted data byte, while chip select stays low, are ignored.
- R10: A read transfer leaves the register bank unchanged. Output data bits change only after a falling serial-clock edge or when chip select goes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_i | input | 1 | Serial data into the port |
| sdio_o | output | 1 | Read data for the shared pin in bidirectional mode |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Read data on the dedicated output pin |
| reg_bus | output | 256 | All registers, register n at bits 8n+7:8n |

## Verification
On every cycle the assertions check four things: the reset state, that the bank moves only after a completed byte commit, that the output pins change only after a falling serial-clock edge or the end of chip select, and that the pad enable appears only in bidirectional mode while selected. The address stepping, the bit order of command and data, the mid-transfer reconfiguration through register 0, the aborts and the ignored trailing bits are all sequences. Only the bench's directed and random transfers, compared with a bench model of the bank, can show them.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W        = 8;
  localparam int ADDR_W        = 5;
  localparam int CNT_W         = 2;
  localparam int CMD_RW_BIT    = 7;
  localparam int CMD_CNT_LSB   = 5;
  localparam int CFG_LSB_BIT   = 6;
  localparam int CFG_BIDIR_BIT = 7;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_IDLE = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  // each stage holds {cs_n, sclk, sdi}
  logic [STAGES-1:0][2:0] pipe;
  logic                   sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b100;
      sclk_d <= 1'b0;
    end else begin
      pipe[0] <= {cs_n, sclk, sdi};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_d <= pipe[STAGES-1][1];
    end
  end

  assign cs_act    = ~pipe[STAGES-1][2];
  assign sclk_rise =  pipe[STAGES-1][1] & ~sclk_d;
  assign sclk_fall = ~pipe[STAGES-1][1] &  sclk_d;
  assign sdi_s     =  pipe[STAGES-1][0];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank import spi_port_pkg::*; #(
  parameter int NREGS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [BYTE_W-1:0]         rd_data,
  output logic [NREGS*BYTE_W-1:0]   reg_bus,
  output logic                      cfg_lsb,
  output logic                      cfg_bidir
);
  localparam int  IW   = $clog2(NREGS);
  localparam bit  FULL = (NREGS == (1 << ADDR_W));

  logic [BYTE_W-1:0] regs [NREGS];
  logic              wr_ok;
  logic              rd_ok;

  generate
    if (FULL) begin : g_full
      assign wr_ok = 1'b1;
      assign rd_ok = 1'b1;
    end else begin : g_part
      assign wr_ok = (wr_addr < ADDR_W'(NREGS));
      assign rd_ok = (rd_addr < ADDR_W'(NREGS));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && wr_ok) begin
      regs[wr_addr[IW-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_ok ? regs[rd_addr[IW-1:0]] : '0;

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_bus
      assign reg_bus[g*BYTE_W +: BYTE_W] = regs[g];
    end
  endgenerate

  assign cfg_lsb   = regs[0][CFG_LSB_BIT];
  assign cfg_bidir = regs[0][CFG_BIDIR_BIT];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine import spi_port_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic              cfg_lsb,
  input  logic              cfg_bidir,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdio_o,
  output logic              sdio_oe
);
  phase_e            phase;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shift_nxt;
  logic              rw;
  logic [CNT_W-1:0]  left;
  logic              lsb_after;
  logic [ADDR_W-1:0] addr_nxt;
  logic              out_bit;

  always_comb begin
    shift_nxt = cfg_lsb ? {sdi_s, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], sdi_s};
    // a write landing in register 0 sets the order for the following step
    lsb_after = (!rw && addr == '0) ? shift_nxt[CFG_LSB_BIT] : cfg_lsb;
    addr_nxt  = lsb_after ? addr + 1'b1 : addr - 1'b1;
    out_bit   = rd_data[cfg_lsb ? bitcnt : ~bitcnt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      left    <= '0;
      addr    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_CMD;
        bitcnt  <= '0;
        sdo     <= 1'b0;
        sdio_o  <= 1'b0;
        sdio_oe <= 1'b0;
      end else begin
        if (sclk_rise) begin
          shreg  <= shift_nxt;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            case (phase)
              PH_CMD: begin
                rw    <= shift_nxt[CMD_RW_BIT];
                left  <= shift_nxt[CMD_CNT_LSB +: CNT_W];
                addr  <= shift_nxt[ADDR_W-1:0];
                phase <= PH_DATA;
              end
              PH_DATA: begin
                if (!rw) begin
                  wr_en   <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= shift_nxt;
                end
                addr <= addr_nxt;
                if (left == '0) phase <= PH_IDLE;
                else            left  <= left - 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (sclk_fall && phase == PH_DATA && rw) begin
          if (cfg_bidir) begin
            sdio_o  <= out_bit;
            sdio_oe <= 1'b1;
            sdo     <= 1'b0;
          end else begin
            sdo     <= out_bit;
            sdio_o  <= 1'b0;
            sdio_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port import spi_port_pkg::*; #(
  parameter int NREGS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdio_i,
  output logic                    sdio_o,
  output logic                    sdio_oe,
  output logic                    sdo,
  output logic [NREGS*BYTE_W-1:0] reg_bus
);
  logic              cs_act;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              sdi_s;
  logic              cfg_lsb;
  logic              cfg_bidir;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdio_i),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .cfg_lsb(cfg_lsb),
    .cfg_bidir(cfg_bidir), .rd_data(rd_data), .addr(cur_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  spi_reg_bank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(rd_data),
    .reg_bus(reg_bus), .cfg_lsb(cfg_lsb), .cfg_bidir(cfg_bidir)
  );
endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk #(
  parameter int NREGS = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           cs_act,
  input logic           sclk_fall,
  input logic           wr_en,
  input logic           sdo,
  input logic           sdio_o,
  input logic           sdio_oe,
  input logic [NREGS*8-1:0] reg_bus
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (reg_bus == '0 && !sdio_oe && !sdo)); // R1

  AST_BANK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_bus) |-> $past(wr_en)); // R3

  AST_OE_ONLY_BIDIR: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> (reg_bus[7] && $past(cs_act))); // R6

  AST_SDO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($past(sclk_fall) || !$past(cs_act))); // R10

  AST_SDIO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdio_o) |-> ($past(sclk_fall) || !$past(cs_act))); // R10
endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .wr_en(wr_en), .sdo(sdo), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
  .reg_bus(reg_bus)
);

// File: tb/spi_ctrl_port_test.sv
`timescale 1ns/1ps
module spi_ctrl_port_test;
  localparam int H = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         sdio_i = 1'b0;
  logic         sdio_o;
  logic         sdio_oe;
  logic         sdo;
  logic [255:0] reg_bus;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [7:0] model [32];
  logic [7:0] wbuf  [4];

  always #2 clk = ~clk;

  spi_ctrl_port uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .reg_bus(reg_bus)
  );

  function automatic logic [255:0] flat();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [4:0] step(input logic [4:0] a, input bit lsb);
    return lsb ? a + 5'd1 : a - 5'd1;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_byte(input logic [7:0] wb, input bit lsb, input bit rd,
                            input bit bidir, input string tag,
                            output logic [7:0] rb);
    rb = '0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      sdio_i = wb[idx];
      waitc(H);
      rb[idx] = bidir ? sdio_o : sdo;
      if (rd && i == 0)
        check(sdio_oe == bidir, tag, 256'(sdio_oe), 256'(bidir));
      sclk = 1'b1;
      waitc(H);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input bit rd, input int n, input logic [4:0] a0,
                      input string tag);
    logic [7:0] ins, rb;
    logic [4:0] a;
    bit lsb, bid;
    a   = a0;
    ins = {rd, 2'(n - 1), a0};
    lsb = model[0][6];
    bid = model[0][7];
    cs_n = 1'b0;
    waitc(H);
    shift_byte(ins, lsb, 0, bid, tag, rb);
    for (int k = 0; k < n; k++) begin
      if (rd) begin
        shift_byte(8'h00, lsb, 1, bid, tag, rb);
        check(rb == model[a], tag, 256'(rb), 256'(model[a]));
      end else begin
        shift_byte(wbuf[k], lsb, 0, bid, tag, rb);
        model[a] = wbuf[k];
        lsb = model[0][6];
        bid = model[0][7];
      end
      a = step(a, lsb);
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(2 * H);
    check(reg_bus == flat(), rd ? "R10" : tag, reg_bus, flat());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    waitc(5);
    rst = 1'b0;
    waitc(2);
    // R1 reset state
    check(reg_bus == '0, "R1", reg_bus, '0);
    check(!sdio_oe && !sdo, "R1", 256'({sdio_oe, sdo}), '0);

    // R4 MSB-first multibyte write steps down, then read back (R2)
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    xfer(0, 4, 5'd10, "R4");
    xfer(1, 4, 5'd10, "R2");
    // R4 wrap from address 0 down to 31, keeping register 0 at zero
    wbuf[0] = 8'h00; wbuf[1] = 8'h9C;
    xfer(0, 2, 5'd0, "R4");
    xfer(1, 1, 5'd31, "R2");

    // R7 register 0 switched to LSB first mid-transfer; next byte goes up to 1
    wbuf[0] = 8'h40; wbuf[1] = 8'hA5;
    xfer(0, 2, 5'd0, "R7");
    // R5 LSB-first writes step up and read back
    wbuf[0] = 8'h3C; wbuf[1] = 8'h81; wbuf[2] = 8'h07;
    xfer(0, 3, 5'd20, "R5");
    xfer(1, 3, 5'd20, "R5");

    // R6 bidirectional mode: reads on sdio_o with enable high
    wbuf[0] = 8'hC0;
    xfer(0, 1, 5'd0, "R6");
    xfer(1, 3, 5'd20, "R6");
    // back to MSB first, input only
    wbuf[0] = 8'h00;
    xfer(0, 1, 5'd0, "R6");
    xfer(1, 2, 5'd11, "R6");

    // R9 extra byte after the counted data is ignored
    cs_n = 1'b0; waitc(H);
    shift_byte({1'b0, 2'd0, 5'd9}, 0, 0, 0, "R9", rb);
    shift_byte(8'h5A, 0, 0, 0, "R9", rb);
    shift_byte(8'hFF, 0, 0, 0, "R9", rb);
    waitc(H); cs_n = 1'b1; waitc(2 * H);
    model[9] = 8'h5A;
    check(reg_bus == flat(), "R9", reg_bus, flat());

    // R8 abort mid data byte discards it
    cs_n = 1'b0; waitc(H);
    shift_byte({1'b0, 2'd0, 5'd3}, 0, 0, 0, "R8", rb);
    for (int i = 0; i < 5; i++) begin
      sdio_i = 1'b1; waitc(H); sclk = 1'b1; waitc(H); sclk = 1'b0;
    end
    waitc(H); cs_n = 1'b1; waitc(2 * H);
    check(reg_bus == flat(), "R8", reg_bus, flat());
    // R8 abort inside the command, then a fresh transfer decodes cleanly
    cs_n = 1'b0; waitc(H);
    for (int i = 0; i < 3; i++) begin
      sdio_i = 1'b1; waitc(H); sclk = 1'b1; waitc(H); sclk = 1'b0;
    end
    waitc(H); cs_n = 1'b1; waitc(2 * H);
    wbuf[0] = 8'hE1;
    xfer(0, 1, 5'd3, "R8");
    xfer(1, 1, 5'd3, "R8");

    // random transfers, R2 reads and R3 writes against the model
    for (int t = 0; t < 60; t++) begin
      bit rd;
      int n;
      logic [4:0] a;
      rd = 1'($urandom % 2);
      n  = 1 + int'($urandom % 4);
      a  = 5'($urandom % 32);
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
      xfer(rd, n, a, rd ? "R2" : "R3");
    end

    // final sweep of the whole bank
    for (int b = 0; b < 8; b++) xfer(1, 4, 5'(b * 4 + 3), "R2");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule